// File: doc/BRIEF.md
# Offset and Gain Calibration Sequencer

This block is the control state machine of a background calibration loop. It has two measurement channels, horizontal and vertical, and two compensation kinds, offset and gain. Once its run conditions hold, it steps through every enabled compensation kind on both channels, over and over. The order is fixed: offset before gain, and horizontal before vertical. Each step is a handshake with an external measure-and-adjust unit. The sequencer pulses a start strobe and then waits for that unit's done flag. While the step is in flight, it presents the measurement mode and the channel select to the unit.

While the loop is active, the sequencer forces the correction-RAM update enables low so that the host cannot disturb the tables being calibrated. When the loop is idle, the host's own enable values pass through. A status flag starts high at reset and drops once every enabled channel has been compensated for the first time. The host polls this flag to learn that the first calibration has settled.

The run conditions are:
- the configuration load has finished,
- every output-enable bit is 1,
- the stop request is low,
- at least one of the two compensation enables is set.

Losing any one of these returns the sequencer to idle at the next clock edge.

Top module: `cal_loop_seq`

## Requirements
- R1: During and right after synchronous reset, the outputs take these values: `first_pending`=1, `loop_active`=0, `step_start`=0, `ram_upd_en`=0, `mode_gain`=0, `chan_horiz`=1.
- R2: While idle, no step starts unless all of the following hold: `cfg_loaded`=1, every bit of `out_en`=1, `stop_req`=0, and `ofs_en` or `gain_en` is 1. While idle, `ram_upd_en` equals the value `host_ru` had one cycle earlier.
- R3: At the first clock edge where the run conditions hold while idle, the sequencer becomes active. In the following cycle, `step_start`=1, `loop_active`=1 and `ram_upd_en`=0.
- R4: An offset step drives `mode_gain`=0. An offset pass runs the horizontal step (`chan_horiz`=1) first and then the vertical step (`chan_horiz`=0). Mode and channel stay constant while a step is in flight.
- R5: A gain step drives `mode_gain`=1 and uses the same horizontal-then-vertical order. When both kinds are enabled, the gain pass directly follows the offset pass.
- R6: A kind whose enable bit is 0 is skipped. The enabled passes repeat without end.
- R7: `step_start` is high for exactly one cycle per step. The next step's `step_start` appears in the cycle right after the edge at which `step_done`=1 is sampled while a step is waiting. A `step_done` seen in the cycle of `step_start` itself is ignored.
- R8: If a run condition is lost, the next edge makes these outputs hold: `loop_active`=0, `step_start`=0, `mode_gain`=0, `chan_horiz`=1, and `ram_upd_en` equals `host_ru`. When the run conditions return, the sequence restarts from the horizontal step of the first enabled kind.
- R9: `first_pending` drops at the edge that accepts `step_done` for the vertical step of the last enabled kind in a round. This is the gain pass if `gain_en`=1, and the offset pass otherwise. A stop before that point leaves it high. Once low, it stays low until reset.
- R10: Whenever `loop_active`=1, `ram_upd_en`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_loaded | input | 1 | Configuration load finished |
| out_en | input | OE_W (2) | Output-enable bits; all must be 1 to run |
| stop_req | input | 1 | Stop request; 1 halts the loop |
| ofs_en | input | 1 | Offset compensation enable |
| gain_en | input | 1 | Gain compensation enable |
| host_ru | input | RU_W (2) | Host-written RAM-update enable values |
| step_done | input | 1 | Measure-and-adjust unit finished the current step |
| step_start | output | 1 | One-cycle start strobe for a step |
| mode_gain | output | 1 | Measurement mode: 0 offset, 1 gain |
| chan_horiz | output | 1 | Channel select: 1 horizontal, 0 vertical |
| ram_upd_en | output | RU_W (2) | Effective RAM-update enables |
| first_pending | output | 1 | High until the first full round completes |
| loop_active | output | 1 | Sequencer is running a step |

## Verification
The sweep covers every non-zero combination of the two enable bits together with done latencies from zero to three cycles. Running offset only, gain only and both kinds shows whether a disabled pass is really skipped and whether the pass order and channel order are right. Varying the latency shows whether the next start strobe follows the done edge exactly rather than a fixed delay. Each run ends by dropping a different run condition. This shows that each condition alone forces idle, that the host RAM-enable values return, and that the restart point is correct. A separate run stops the loop before the first round completes and then feeds `step_done` during a start cycle. This separates a status flag that clears early or re-arms from one that holds, and a handshake that acts on a stale done from one that ignores it.

// File: rtl/cal_loop_pkg.sv
package cal_loop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  localparam logic MODE_OFFSET = 1'b0;
  localparam logic MODE_GAIN   = 1'b1;
  localparam logic CH_HORIZ    = 1'b1;
  localparam logic CH_VERT     = 1'b0;

endpackage

// File: rtl/cal_run_gate.sv
module cal_run_gate #(
  parameter int OE_W = 2
) (
  input  logic            cfg_loaded,
  input  logic [OE_W-1:0] out_en,
  input  logic            stop_req,
  input  logic            ofs_en,
  input  logic            gain_en,
  output logic            run_ok
);
  localparam logic [OE_W-1:0] OE_ALL = {OE_W{1'b1}};

  logic outputs_on;
  logic any_kind;

  assign outputs_on = (out_en == OE_ALL);
  assign any_kind   = ofs_en | gain_en;
  assign run_ok     = cfg_loaded & outputs_on & ~stop_req & any_kind;
endmodule

// File: rtl/cal_step_fsm.sv
module cal_step_fsm
  import cal_loop_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run_ok,
  input  logic ofs_en,
  input  logic gain_en,
  input  logic step_done,
  output logic step_start,
  output logic mode_gain,
  output logic chan_horiz,
  output logic loop_active,
  output logic next_idle,
  output logic round_done
);
  seq_state_e state_q, state_d;
  logic       mode_q, mode_d;
  logic       chan_q, chan_d;
  logic       first_kind;

  // First enabled kind of a round: offset wins when enabled.
  assign first_kind = ofs_en ? MODE_OFFSET : MODE_GAIN;

  always_comb begin
    state_d    = state_q;
    mode_d     = mode_q;
    chan_d     = chan_q;
    round_done = 1'b0;
    if (!run_ok) begin
      state_d = ST_IDLE;
      mode_d  = MODE_OFFSET;
      chan_d  = CH_HORIZ;
    end else begin
      case (state_q)
        ST_IDLE: begin
          state_d = ST_ISSUE;
          mode_d  = first_kind;
          chan_d  = CH_HORIZ;
        end
        ST_ISSUE: state_d = ST_WAIT;
        ST_WAIT: begin
          if (step_done) begin
            state_d = ST_ISSUE;
            if (chan_q == CH_HORIZ) begin
              chan_d = CH_VERT;
            end else begin
              chan_d = CH_HORIZ;
              if (mode_q == MODE_OFFSET) begin
                mode_d     = gain_en ? MODE_GAIN : MODE_OFFSET;
                round_done = ~gain_en;
              end else begin
                mode_d     = first_kind;
                round_done = 1'b1;
              end
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_OFFSET;
      chan_q  <= CH_HORIZ;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      chan_q  <= chan_d;
    end
  end

  assign step_start  = (state_q == ST_ISSUE);
  assign loop_active = (state_q != ST_IDLE);
  assign next_idle   = (state_d == ST_IDLE);
  assign mode_gain   = mode_q;
  assign chan_horiz  = chan_q;
endmodule

// File: rtl/cal_status_regs.sv
module cal_status_regs #(
  parameter int RU_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            next_idle,
  input  logic            round_done,
  input  logic [RU_W-1:0] host_ru,
  output logic [RU_W-1:0] ram_upd_en,
  output logic            first_pending
);
  localparam logic [RU_W-1:0] RU_BLOCKED = {RU_W{1'b0}};

  always_ff @(posedge clk) begin
    if (rst) begin
      first_pending <= 1'b1;
      ram_upd_en    <= RU_BLOCKED;
    end else begin
      if (round_done) first_pending <= 1'b0;
      ram_upd_en <= next_idle ? host_ru : RU_BLOCKED;
    end
  end
endmodule

// File: rtl/cal_loop_seq.sv
module cal_loop_seq #(
  parameter int OE_W = 2,
  parameter int RU_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_loaded,
  input  logic [OE_W-1:0] out_en,
  input  logic            stop_req,
  input  logic            ofs_en,
  input  logic            gain_en,
  input  logic [RU_W-1:0] host_ru,
  input  logic            step_done,
  output logic            step_start,
  output logic            mode_gain,
  output logic            chan_horiz,
  output logic [RU_W-1:0] ram_upd_en,
  output logic            first_pending,
  output logic            loop_active
);
  logic run_ok;
  logic next_idle;
  logic round_done;

  cal_run_gate #(.OE_W(OE_W)) u_gate (
    .cfg_loaded (cfg_loaded),
    .out_en     (out_en),
    .stop_req   (stop_req),
    .ofs_en     (ofs_en),
    .gain_en    (gain_en),
    .run_ok     (run_ok)
  );

  cal_step_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .run_ok      (run_ok),
    .ofs_en      (ofs_en),
    .gain_en     (gain_en),
    .step_done   (step_done),
    .step_start  (step_start),
    .mode_gain   (mode_gain),
    .chan_horiz  (chan_horiz),
    .loop_active (loop_active),
    .next_idle   (next_idle),
    .round_done  (round_done)
  );

  cal_status_regs #(.RU_W(RU_W)) u_status (
    .clk           (clk),
    .rst           (rst),
    .next_idle     (next_idle),
    .round_done    (round_done),
    .host_ru       (host_ru),
    .ram_upd_en    (ram_upd_en),
    .first_pending (first_pending)
  );
endmodule

// File: rtl/cal_loop_seq_chk.sv
module cal_loop_seq_chk #(
  parameter int OE_W = 2,
  parameter int RU_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_loaded,
  input logic [OE_W-1:0] out_en,
  input logic            stop_req,
  input logic            ofs_en,
  input logic            gain_en,
  input logic [RU_W-1:0] host_ru,
  input logic            step_start,
  input logic            mode_gain,
  input logic            chan_horiz,
  input logic [RU_W-1:0] ram_upd_en,
  input logic            first_pending,
  input logic            loop_active
);
  logic may_run;
  assign may_run = cfg_loaded && (&out_en) && !stop_req && (ofs_en || gain_en);

  p_halt_r8: assert property (@(posedge clk) disable iff (rst)
    !may_run |=> !loop_active);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !loop_active && !may_run |=> !step_start);

  p_idle_ru_r2: assert property (@(posedge clk) disable iff (rst)
    !loop_active && !$past(rst) |-> ram_upd_en == $past(host_ru));

  p_ru_blocked_r10: assert property (@(posedge clk) disable iff (rst)
    loop_active |-> ram_upd_en == '0);

  p_start_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    step_start |=> !step_start);

  p_step_stable_r4: assert property (@(posedge clk) disable iff (rst)
    loop_active && !step_start && $past(loop_active) |->
      $stable(mode_gain) && $stable(chan_horiz));

  p_pending_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    !first_pending |=> !first_pending);
endmodule

bind cal_loop_seq cal_loop_seq_chk #(.OE_W(OE_W), .RU_W(RU_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_loaded    (cfg_loaded),
  .out_en        (out_en),
  .stop_req      (stop_req),
  .ofs_en        (ofs_en),
  .gain_en       (gain_en),
  .host_ru       (host_ru),
  .step_start    (step_start),
  .mode_gain     (mode_gain),
  .chan_horiz    (chan_horiz),
  .ram_upd_en    (ram_upd_en),
  .first_pending (first_pending),
  .loop_active   (loop_active)
);

// File: tb/cal_loop_seq_tb.sv
module cal_loop_seq_tb;
  localparam int OE_W = 2;
  localparam int RU_W = 2;

  logic            clk = 1'b0;
  logic            rst;
  logic            cfg_loaded;
  logic [OE_W-1:0] out_en;
  logic            stop_req;
  logic            ofs_en;
  logic            gain_en;
  logic [RU_W-1:0] host_ru;
  logic            step_done;
  logic            step_start;
  logic            mode_gain;
  logic            chan_horiz;
  logic [RU_W-1:0] ram_upd_en;
  logic            first_pending;
  logic            loop_active;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  cal_loop_seq #(.OE_W(OE_W), .RU_W(RU_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_loaded(cfg_loaded), .out_en(out_en),
    .stop_req(stop_req), .ofs_en(ofs_en), .gain_en(gain_en),
    .host_ru(host_ru), .step_done(step_done), .step_start(step_start),
    .mode_gain(mode_gain), .chan_horiz(chan_horiz), .ram_upd_en(ram_upd_en),
    .first_pending(first_pending), .loop_active(loop_active)
  );

  initial forever #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; cfg_loaded = 1'b0; out_en = '0; stop_req = 1'b0;
    ofs_en = 1'b0; gain_en = 1'b0; host_ru = 2'b11; step_done = 1'b0;
    tick(); tick();
    chk("R1", "first_pending", int'(first_pending), 1);
    chk("R1", "loop_active", int'(loop_active), 0);
    chk("R1", "step_start", int'(step_start), 0);
    chk("R1", "ram_upd_en", int'(ram_upd_en), 0);
    chk("R1", "mode_gain", int'(mode_gain), 0);
    chk("R1", "chan_horiz", int'(chan_horiz), 1);
    rst = 1'b0;
  endtask

  // At a step_start cycle: check, then complete the step after lat extra cycles.
  task automatic run_step(input int exp_mode, input int exp_chan, input int exp_pend, input int lat);
    chk("R7", "step_start", int'(step_start), 1);
    chk(exp_mode != 0 ? "R5" : "R4", "mode_gain", int'(mode_gain), exp_mode);
    chk("R4", "chan_horiz", int'(chan_horiz), exp_chan);
    chk("R9", "first_pending", int'(first_pending), exp_pend);
    tick();
    chk("R7", "start_pulse_width", int'(step_start), 0);
    chk("R10", "ram_upd_en_active", int'(ram_upd_en), 0);
    for (int i = 0; i < lat; i++) tick();
    step_done = 1'b1;
    tick();
    step_done = 1'b0;
  endtask

  initial begin
    // Sweep: enable combinations x done latency, ending with a distinct stop cause.
    for (int en = 1; en <= 3; en++) begin
      for (int lat = 0; lat <= 3; lat++) begin
        int len;
        int first_mode;
        do_reset();
        host_ru = 2'(en);
        ofs_en = (en & 1) != 0;
        gain_en = (en & 2) != 0;
        out_en = 2'b11;
        tick();
        chk("R2", "idle_no_cfg_active", int'(loop_active), 0);
        chk("R2", "idle_ru_follows_host", int'(ram_upd_en), en);
        step_done = 1'b1;
        tick();
        step_done = 1'b0;
        chk("R2", "done_while_idle", int'(step_start), 0);
        cfg_loaded = 1'b1;
        tick();
        chk("R3", "loop_active", int'(loop_active), 1);
        chk("R3", "ram_upd_en", int'(ram_upd_en), 0);
        len = ((en & 1) != 0 ? 1 : 0) + ((en & 2) != 0 ? 1 : 0);
        first_mode = ((en & 1) != 0) ? 0 : 1;
        for (int k = 0; k < 6 * len; k++) begin
          int m;
          m = (len == 2) ? ((k / 2) % 2) : first_mode;   // R6: disabled kind skipped
          run_step(m, (k % 2 == 0) ? 1 : 0, (k < 2 * len) ? 1 : 0, lat);
        end
        chk("R6", "repeat_start", int'(step_start), 1);
        host_ru = 2'b01;
        case (lat)
          0: out_en[0] = 1'b0;
          1: out_en[1] = 1'b0;
          2: stop_req = 1'b1;
          default: begin ofs_en = 1'b0; gain_en = 1'b0; end
        endcase
        tick();
        chk("R8", "loop_active_stop", int'(loop_active), 0);
        chk("R8", "step_start_stop", int'(step_start), 0);
        chk("R8", "ram_upd_en_host", int'(ram_upd_en), 1);
        chk("R8", "mode_rest", int'(mode_gain), 0);
        chk("R8", "chan_rest", int'(chan_horiz), 1);
        tick();
        chk("R8", "stay_idle", int'(loop_active), 0);
        chk("R9", "pending_stays_low", int'(first_pending), 0);
        out_en = 2'b11; stop_req = 1'b0;
        ofs_en = (en & 1) != 0; gain_en = (en & 2) != 0;
        tick();
        chk("R8", "restart_start", int'(step_start), 1);
        chk("R8", "restart_mode", int'(mode_gain), first_mode);
        chk("R8", "restart_chan", int'(chan_horiz), 1);
      end
    end

    // Early stop keeps first_pending; done during a start cycle is ignored.
    do_reset();
    cfg_loaded = 1'b1; out_en = 2'b11; ofs_en = 1'b1; gain_en = 1'b1;
    tick();
    run_step(0, 1, 1, 1);
    chk("R4", "offset_vert_start", int'(chan_horiz), 0);
    tick();
    stop_req = 1'b1;
    tick();
    chk("R9", "pending_after_early_stop", int'(first_pending), 1);
    chk("R8", "early_stop_idle", int'(loop_active), 0);
    stop_req = 1'b0;
    tick();
    chk("R8", "early_restart_chan", int'(chan_horiz), 1);
    step_done = 1'b1;                  // present during the start cycle
    tick();
    chk("R7", "done_in_start_ignored_chan", int'(chan_horiz), 1);
    chk("R7", "done_in_start_no_restart", int'(step_start), 0);
    tick();                            // now accepted while waiting
    step_done = 1'b0;
    chk("R7", "next_start_after_done", int'(step_start), 1);
    run_step(0, 0, 1, 0);
    run_step(1, 1, 1, 2);
    run_step(1, 0, 1, 0);
    chk("R9", "pending_clears_after_round", int'(first_pending), 0);
    chk("R5", "wrap_to_offset", int'(mode_gain), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R7 watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule